// File: doc/BRIEF.md
# Selectable Bipolar Line Codec (AMI / B8ZS / HDB3)

This block sits between a DS1/E1 test-stream source or sink and a dual-rail line interface. In the transmit direction it takes an NRZ bit stream and produces a pair of rail signals, each carrying one polarity of a bipolar pulse. In the receive direction it takes a rail pair and recovers the NRZ stream. A single 2-bit provisioned mode picks the coding for both directions at once: uncoded, AMI, B8ZS or HDB3.

When the block is uncoded, the two line pins carry plain data and frame sync. When it is coded, the same pins are reused: the data pin becomes the positive rail and the sync pin becomes the negative rail. In the two zero-substituting modes, the transmitter holds bits in a short window so that a long run of zeros can be rewritten before it leaves. The receiver uses a window of the same depth to find and remove each substitution. The receiver also has a flag for the illegal case where both rails pulse in the same bit period.

The mode is static provisioning. It is changed only while reset is held.

Top module: `lc_line_codec`

## Requirements
- R1: The `mode` input selects the coding for transmit and receive together: 2'b00 uncoded, 2'b01 AMI, 2'b10 B8ZS, 2'b11 HDB3.
- R2: Uncoded mode, transmit: `tx_pos_out` repeats `tx_data_in` and `tx_neg_out` repeats `tx_sync_in`, one clock after the edge that samples them. Uncoded mode, receive: `rx_data_out` repeats `rx_pos_in` and `rx_sync_out` repeats `rx_neg_in`, also one clock after sampling.
- R3: In every coded mode, `tx_pos_out` (positive rail) and `tx_neg_out` (negative rail) are never high together, and neither rail pulses in two consecutive bit periods.
- R4: AMI, transmit: each one is sent as a pulse, on the rail opposite to the previous pulse. The first pulse after reset is positive. Each zero is sent as no pulse. A bit sampled at edge k appears just after edge k+1.
- R5: B8ZS, transmit: every run of eight zeros is sent as 000VB0VB. V is a pulse with the same polarity as the pulse before it, and B is a pulse with the opposite polarity. A bit sampled at edge k appears just after edge k+8.
- R6: HDB3, transmit: every run of four zeros is sent as 000V when an odd number of pulses has been sent since the last V, and as B00V when that number is even. The count starts at zero after reset. A bit sampled at edge k appears just after edge k+4.
- R7: In coded modes, `rx_data_out` is high for every received pulse except the pulses of a recognised substitution, which decode as zeros. `rx_sync_out` stays low. The receive delay is the same as the transmit delay of the mode, so a transmit-to-receive loopback returns the original stream.
- R8: In coded modes, `rx_bpv_flag` is high one clock after an edge at which `rx_pos_in` and `rx_neg_in` were both high, and low otherwise. In uncoded mode it stays low.
- R9: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Coding select, shared by both directions |
| tx_data_in | input | 1 | NRZ transmit data |
| tx_sync_in | input | 1 | Transmit frame sync (used in uncoded mode only) |
| tx_pos_out | output | 1 | Line data pin, positive rail when coded |
| tx_neg_out | output | 1 | Line sync pin, negative rail when coded |
| rx_pos_in | input | 1 | Received data pin, positive rail when coded |
| rx_neg_in | input | 1 | Received sync pin, negative rail when coded |
| rx_data_out | output | 1 | Recovered NRZ data |
| rx_sync_out | output | 1 | Recovered frame sync (uncoded mode only) |
| rx_bpv_flag | output | 1 | Both rails pulsed in one bit period |

## Verification
The hardest case to reach is HDB3 with every combination of pulse-count parity and zero-run length. This includes runs that end one short of a substitution and runs long enough for several substitutions back to back. The stimulus sweeps zero runs of 0 to 20 bits, each preceded by one, two or three ones. This walks the parity through both values at every run length and also covers the B8ZS boundary at seven, eight and sixteen zeros. The transmitter output is compared bit by bit against an encoding the bench computes for the whole sequence in one pass. The transmit rails are looped back into the receiver, so the same sweep shows that every substitution is removed.

// File: rtl/lc_pkg.sv
// Package lc_pkg: shared types and constants for the bipolar line codec.
// Assumes the window depth used by the codec is at least B8ZS_RUN.
package lc_pkg;

    // Line coding selection, shared by both directions.
    typedef enum logic [1:0] {
        LC_RAW  = 2'b00,
        LC_AMI  = 2'b01,
        LC_B8ZS = 2'b10,
        LC_HDB3 = 2'b11
    } lc_mode_e;

    // Marking on a transmit window slot that replaces a zero.
    typedef enum logic [1:0] {
        SUB_NONE = 2'd0,
        SUB_BIP  = 2'd1,
        SUB_VIOL = 2'd2
    } sub_e;

    // Zero-run lengths that trigger a substitution.
    localparam int B8ZS_RUN = 8;
    localparam int HDB3_RUN = 4;

endpackage

// File: rtl/lc_line_encoder.sv
// Module lc_line_encoder: NRZ to dual-rail encoder with AMI/B8ZS/HDB3.
// Incoming bits pass through a WIN-deep window. A zero-run counter on the
// input side marks window slots as B or V as soon as a run completes.
// The output polarity is chosen as each slot leaves through a
// mode-dependent tap. Assumes mode is static outside reset and WIN >= 8.
module lc_line_encoder
    import lc_pkg::*;
#(
    parameter int WIN = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  lc_mode_e mode,
    input  logic     din,
    input  logic     sin,
    output logic     pos_o,
    output logic     neg_o
);
    localparam int RUN_W = $clog2(WIN + 1);
    localparam int TAP_W = $clog2(WIN);

    logic [WIN-1:0]   one_q, one_d;
    sub_e             tag_q [WIN];
    sub_e             tag_d [WIN];
    logic [RUN_W-1:0] run_q, run_d, run_lim;
    logic             par_q, par_d;
    logic             lpol_q;
    logic             sync_q;
    logic [TAP_W-1:0] tap_idx;
    logic             subst_mode, coded;
    logic             tap_one, pulse, pol;
    sub_e             tap_tag;

    assign subst_mode = (mode == LC_B8ZS) || (mode == LC_HDB3);
    assign coded      = (mode != LC_RAW);
    assign run_lim    = (mode == LC_B8ZS) ? RUN_W'(B8ZS_RUN) : RUN_W'(HDB3_RUN);

    // Pick the window slot that leaves: it sets the delay of each mode.
    always_comb begin
        case (mode)
            LC_B8ZS: tap_idx = TAP_W'(B8ZS_RUN - 1);
            LC_HDB3: tap_idx = TAP_W'(HDB3_RUN - 1);
            default: tap_idx = '0;
        endcase
    end

    // Shift the window and mark a completed zero run with its pattern.
    always_comb begin
        one_d     = {one_q[WIN-2:0], din};
        tag_d[0]  = SUB_NONE;
        for (int i = 1; i < WIN; i++) begin
            tag_d[i] = tag_q[i-1];
        end
        run_d = '0;
        par_d = 1'b0;
        if (subst_mode) begin
            if (din) begin
                run_d = '0;
                par_d = ~par_q;
            end else if (run_q == run_lim - 1'b1) begin
                run_d = '0;
                par_d = 1'b0;
                if (mode == LC_B8ZS) begin
                    // oldest slot 7 ... newest slot 0 : 0 0 0 V B 0 V B
                    tag_d[4] = SUB_VIOL;
                    tag_d[3] = SUB_BIP;
                    tag_d[1] = SUB_VIOL;
                    tag_d[0] = SUB_BIP;
                end else begin
                    // oldest slot 3 ... newest slot 0 : B/0 0 0 V
                    tag_d[0] = SUB_VIOL;
                    if (!par_q) begin
                        tag_d[HDB3_RUN-1] = SUB_BIP;
                    end
                end
            end else begin
                run_d = run_q + 1'b1;
                par_d = par_q;
            end
        end
    end

    // Work out the pulse and its polarity for the slot that leaves.
    always_comb begin
        tap_one = one_q[tap_idx];
        tap_tag = tag_q[tap_idx];
        pulse   = coded && (tap_one || (tap_tag != SUB_NONE));
        pol     = (tap_tag == SUB_VIOL) ? lpol_q : ~lpol_q;
    end

    // Window, run and parity state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            one_q <= '0;
            run_q <= '0;
            par_q <= 1'b0;
            for (int i = 0; i < WIN; i++) begin
                tag_q[i] <= SUB_NONE;
            end
        end else begin
            one_q <= one_d;
            run_q <= run_d;
            par_q <= par_d;
            for (int i = 0; i < WIN; i++) begin
                tag_q[i] <= tag_d[i];
            end
        end
    end

    // Registered rail outputs and the polarity of the last pulse sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_o  <= 1'b0;
            neg_o  <= 1'b0;
            lpol_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            sync_q <= sin;
            if (!coded) begin
                pos_o <= tap_one;
                neg_o <= sync_q;
            end else begin
                pos_o <= pulse & pol;
                neg_o <= pulse & ~pol;
                if (pulse) begin
                    lpol_q <= pol;
                end
            end
        end
    end

endmodule

// File: rtl/lc_line_decoder.sv
// Module lc_line_decoder: dual-rail to NRZ decoder.
// Received rail pairs pass through a WIN-deep window. An HDB3 violation at
// the newest slot clears the four newest slots. A full B8ZS pattern seen
// across the eight newest slots clears all eight. The data leaves through
// the same mode-dependent tap as the encoder uses.
// Assumes mode is static outside reset and WIN >= 8.
module lc_line_decoder
    import lc_pkg::*;
#(
    parameter int WIN = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  lc_mode_e mode,
    input  logic     rx_p,
    input  logic     rx_n,
    output logic     data_o,
    output logic     sync_o
);
    localparam int TAP_W = $clog2(WIN);

    logic [WIN-1:0]   p_q, n_q, sh_p, sh_n, p_d, n_d, mk;
    logic             lpol_q;
    logic             m_in, hdb3_hit, b8zs_hit;
    logic [TAP_W-1:0] tap_idx;

    assign m_in = rx_p | rx_n;
    assign sh_p = {p_q[WIN-2:0], rx_p};
    assign sh_n = {n_q[WIN-2:0], rx_n};
    assign mk   = sh_p | sh_n;

    // Choose the output slot to match the delay of the encoder.
    always_comb begin
        case (mode)
            LC_B8ZS: tap_idx = TAP_W'(B8ZS_RUN - 1);
            LC_HDB3: tap_idx = TAP_W'(HDB3_RUN - 1);
            default: tap_idx = '0;
        endcase
    end

    // Recognise substitutions in the shifted window.
    always_comb begin
        hdb3_hit = (mode == LC_HDB3) && m_in && (rx_p == lpol_q);
        b8zs_hit = (mode == LC_B8ZS)
                 && !mk[7] && !mk[6] && !mk[5] && !mk[2]
                 && mk[4] && mk[3] && mk[1] && mk[0]
                 && (sh_p[3] != sh_p[4]) && (sh_p[1] == sh_p[3])
                 && (sh_p[0] == sh_p[4]);
    end

    // Remove the recognised substitution pulses from the next window.
    always_comb begin
        p_d = sh_p;
        n_d = sh_n;
        if (hdb3_hit) begin
            p_d[HDB3_RUN-1:0] = '0;
            n_d[HDB3_RUN-1:0] = '0;
        end
        if (b8zs_hit) begin
            p_d[B8ZS_RUN-1:0] = '0;
            n_d[B8ZS_RUN-1:0] = '0;
        end
    end

    // Window state and the polarity of the last received pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q    <= '0;
            n_q    <= '0;
            lpol_q <= 1'b0;
        end else begin
            p_q <= p_d;
            n_q <= n_d;
            if (m_in) begin
                lpol_q <= rx_p;
            end
        end
    end

    // Registered NRZ data and sync outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= 1'b0;
            sync_o <= 1'b0;
        end else if (mode == LC_RAW) begin
            data_o <= p_q[tap_idx];
            sync_o <= n_q[tap_idx];
        end else begin
            data_o <= p_q[tap_idx] | n_q[tap_idx];
            sync_o <= 1'b0;
        end
    end

endmodule

// File: rtl/lc_rail_clash.sv
// Module lc_rail_clash: flags a bit period in which both received rails
// are high while a coded mode is active. Registered, one clock of delay.
module lc_rail_clash
    import lc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lc_mode_e mode,
    input  logic     rx_p,
    input  logic     rx_n,
    output logic     clash_o
);
    // Sample the coincidence of the two rails.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clash_o <= 1'b0;
        end else begin
            clash_o <= (mode != LC_RAW) && rx_p && rx_n;
        end
    end

endmodule

// File: rtl/lc_line_codec.sv
// Module lc_line_codec: top of the selectable bipolar line codec.
// One mode input drives the transmit encoder, the receive decoder and the
// rail-clash detector. Assumes mode changes only while rst_n is low.
module lc_line_codec
    import lc_pkg::*;
#(
    parameter int WIN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       tx_data_in,
    input  logic       tx_sync_in,
    output logic       tx_pos_out,
    output logic       tx_neg_out,
    input  logic       rx_pos_in,
    input  logic       rx_neg_in,
    output logic       rx_data_out,
    output logic       rx_sync_out,
    output logic       rx_bpv_flag
);
    lc_mode_e mode_e;

    assign mode_e = lc_mode_e'(mode);

    lc_line_encoder #(.WIN(WIN)) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_e),
        .din   (tx_data_in),
        .sin   (tx_sync_in),
        .pos_o (tx_pos_out),
        .neg_o (tx_neg_out)
    );

    lc_line_decoder #(.WIN(WIN)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode_e),
        .rx_p   (rx_pos_in),
        .rx_n   (rx_neg_in),
        .data_o (rx_data_out),
        .sync_o (rx_sync_out)
    );

    lc_rail_clash u_clash (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_e),
        .rx_p    (rx_pos_in),
        .rx_n    (rx_neg_in),
        .clash_o (rx_bpv_flag)
    );

endmodule

// File: rtl/lc_codec_checker.sv
// Module lc_codec_checker: protocol assertions for lc_line_codec, bound to
// every instance of the top module.
module lc_codec_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       tx_pos_out,
    input logic       tx_neg_out,
    input logic       rx_pos_in,
    input logic       rx_neg_in,
    input logic       rx_bpv_flag
);
    // R3: the two transmit rails are never high together in coded modes
    assert_rails_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00) |-> !(tx_pos_out && tx_neg_out));

    // R3: no two consecutive positive pulses
    assert_pos_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && tx_pos_out) |=> !tx_pos_out);

    // R3: no two consecutive negative pulses
    assert_neg_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && tx_neg_out) |=> !tx_neg_out);

    // R8: both rails high in a coded mode raise the flag
    assert_flag_on_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && rx_pos_in && rx_neg_in) |=> rx_bpv_flag);

    // R8: no flag without a coincidence
    assert_flag_needs_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_pos_in && rx_neg_in) |=> !rx_bpv_flag);

    // R8: never a flag while uncoded
    assert_flag_quiet_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> !rx_bpv_flag);

endmodule

bind lc_line_codec lc_codec_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .tx_pos_out  (tx_pos_out),
    .tx_neg_out  (tx_neg_out),
    .rx_pos_in   (rx_pos_in),
    .rx_neg_in   (rx_neg_in),
    .rx_bpv_flag (rx_bpv_flag)
);

// File: tb/lc_line_codec_tb.sv
`timescale 1ns/1ps
module lc_line_codec_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n;
    logic [1:0] mode;
    logic       tx_data_in, tx_sync_in;
    logic       tx_pos_out, tx_neg_out;
    logic       rx_pos_in, rx_neg_in;
    logic       rx_data_out, rx_sync_out, rx_bpv_flag;
    logic       loop_en, drv_p, drv_n;

    assign rx_pos_in = loop_en ? tx_pos_out : drv_p;
    assign rx_neg_in = loop_en ? tx_neg_out : drv_n;

    lc_line_codec u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .tx_data_in  (tx_data_in),
        .tx_sync_in  (tx_sync_in),
        .tx_pos_out  (tx_pos_out),
        .tx_neg_out  (tx_neg_out),
        .rx_pos_in   (rx_pos_in),
        .rx_neg_in   (rx_neg_in),
        .rx_data_out (rx_data_out),
        .rx_sync_out (rx_sync_out),
        .rx_bpv_flag (rx_bpv_flag)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit stim [0:1023];
    bit sy   [0:1023];
    bit ep   [0:1023];
    bit en   [0:1023];
    int nb;

    task automatic chk(input string rq, input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", rq, what, act, exp);
        end
    endtask

    // Sweep: one to three ones, then a zero run of 0..20 bits, then ones as padding.
    task automatic build_stim();
        logic [6:0] l;
        l  = 7'h5A;
        nb = 0;
        for (int r = 0; r <= 20; r++) begin
            for (int o = 1; o <= 3; o++) begin
                for (int k = 0; k < o + r; k++) begin
                    stim[nb] = (k < o);
                    sy[nb]   = l[0];
                    l        = {l[5:0], l[6] ^ l[5]};
                    nb++;
                end
            end
        end
        for (int k = 0; k < 24; k++) begin
            stim[nb] = 1'b1;
            sy[nb]   = 1'b0;
            nb++;
        end
    endtask

    task automatic put(input int idx, input bit pol);
        ep[idx] = pol;
        en[idx] = ~pol;
    endtask

    // Whole-sequence expected line encoding, worked out from R4, R5 and R6.
    task automatic ref_encode(input int md);
        bit lp, par, allz;
        int i, rl;
        lp = 1'b0; par = 1'b0; i = 0;
        rl = (md == 2) ? 8 : 4;
        for (int k = 0; k < nb; k++) begin
            ep[k] = (md == 0) ? stim[k] : 1'b0;
            en[k] = (md == 0) ? sy[k]   : 1'b0;
        end
        if (md == 0) return;
        while (i < nb) begin
            allz = (md >= 2) && (i + rl <= nb);
            if (allz) begin
                for (int k = 0; k < rl; k++) if (stim[i+k]) allz = 1'b0;
            end
            if (allz) begin
                if (md == 2) begin
                    put(i + 3, lp); lp = ~lp; put(i + 4, lp);
                    put(i + 6, lp); lp = ~lp; put(i + 7, lp);
                end else begin
                    if (par) put(i + 3, lp);
                    else begin lp = ~lp; put(i, lp); put(i + 3, lp); end
                    par = 1'b0;
                end
                i += rl;
            end else begin
                if (stim[i]) begin lp = ~lp; put(i, lp); par = ~par; end
                i++;
            end
        end
    endtask

    initial begin
        #(8ns * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        string rq_tx, rq_rx;
        int d, kt, kr;
        rst_n = 1'b0; mode = 2'b00; tx_data_in = 1'b0; tx_sync_in = 1'b0;
        loop_en = 1'b1; drv_p = 1'b0; drv_n = 1'b0;
        build_stim();
        for (int md = 0; md < 4; md++) begin
            @(negedge clk);
            rst_n = 1'b0; mode = 2'(md); loop_en = 1'b1;
            tx_data_in = 1'b1; tx_sync_in = 1'b1;
            repeat (3) @(negedge clk);
            // R9: every output low while reset is held
            chk("R9", tx_pos_out, 1'b0, "reset tx_pos_out");
            chk("R9", tx_neg_out, 1'b0, "reset tx_neg_out");
            chk("R9", rx_data_out, 1'b0, "reset rx_data_out");
            chk("R9", rx_sync_out | rx_bpv_flag, 1'b0, "reset rx_sync/flag");
            tx_data_in = 1'b0; tx_sync_in = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            ref_encode(md);
            d = (md == 2) ? 8 : (md == 3) ? 4 : 1;
            case (md)
                0: rq_tx = "R2";
                1: rq_tx = "R4";
                2: rq_tx = "R5";
                default: rq_tx = "R6";
            endcase
            rq_rx = (md == 0) ? "R2" : "R1 R7";
            for (int j = 0; j < nb + 2 * d + 4; j++) begin
                if (j > 0) @(negedge clk);
                kt = j - 1 - d;
                kr = j - 2 - 2 * d;
                if (kt >= 0 && kt < nb) begin
                    chk(rq_tx, tx_pos_out, ep[kt], $sformatf("tx_pos bit %0d", kt));
                    chk(rq_tx, tx_neg_out, en[kt], $sformatf("tx_neg bit %0d", kt));
                    if (md != 0) chk("R3", tx_pos_out & tx_neg_out, 1'b0, "both rails");
                end
                if (kr >= 0 && kr < nb) begin
                    chk(rq_rx, rx_data_out, stim[kr], $sformatf("rx_data bit %0d", kr));
                    chk(rq_rx, rx_sync_out, (md == 0) ? sy[kr] : 1'b0,
                        $sformatf("rx_sync bit %0d", kr));
                end
                if (j > 1) chk("R8", rx_bpv_flag, 1'b0, "flag during loopback");
                tx_data_in = (j < nb) ? stim[j] : 1'b1;
                tx_sync_in = (j < nb) ? sy[j]   : 1'b0;
            end
            // R8: drive both rails high for one bit period
            loop_en = 1'b0; drv_p = 1'b1; drv_n = 1'b1;
            @(negedge clk);
            drv_p = 1'b0; drv_n = 1'b0;
            chk("R8", rx_bpv_flag, (md != 0), "flag after rail clash");
            @(negedge clk);
            chk("R8", rx_bpv_flag, 1'b0, "flag clears");
            drv_p = 1'b1;
            @(negedge clk);
            drv_p = 1'b0;
            chk("R8", rx_bpv_flag, 1'b0, "flag on single rail");
            loop_en = 1'b1;
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule